// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block decides, for every request that reaches a bridge port, whether the port claims it. It holds the bridge's routing state: a secondary and a subordinate bus number, an I/O window, a 32-bit memory window and a 64-bit prefetchable memory window. Configuration software writes this state through a small register port and can read it back.

A request is presented for one cycle with a one-hot kind (I/O, memory or configuration), a 64-bit address and an 8-bit bus number. One clock later the block reports whether the request hit a window. For a configuration hit it also reports whether the request goes out as Type 0 or as Type 1. A memory request made while memory space is disabled is reported as an unsupported request.

Each window is a base/limit pair. A window whose limit is below its base claims nothing. The reset values leave every address window empty. An I/O window normally has 4 KB granularity. A mode input can refine it to 1 KB.

Top module: `bridge_window_decode`

## Requirements
- R1: After reset the I/O base nibble is 0xF and its limit 0; the memory base field is 0xFFF and its limit 0; the prefetchable base field is 0xFFF with upper word 0xFFFFFFFF, and its limit field and upper word are 0. No I/O or memory address hits after reset. The secondary and subordinate bus numbers reset to 0.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, all other response flags are low. `req_kind` bit 0 marks I/O, bit 1 marks memory and bit 2 marks configuration.
- R3: An I/O request with address bits 63:16 all zero hits when base[7:4] <= A[15:12] <= limit[7:4]. Register 1 holds the base byte in bits 7:0 and the limit byte in bits 15:8. Bits 1:0 of each byte read 0.
- R4: While `io_1k` is 1, bits 3:2 of the I/O base and limit bytes are writable, and the compare becomes {base[7:2]} <= A[15:10] <= {limit[7:2]}. While `io_1k` is 0, those bits read 0, writes to them are dropped, and they take no part in the compare.
- R5: A memory request with A[63:32] zero hits the memory window when base[15:4] <= A[31:20] <= limit[15:4]. Register 2 holds the base in bits 15:0 and the limit in bits 31:16. The low nibble of each half reads 0.
- R6: A memory request hits the prefetchable window when {upper base, base[15:4]} <= A[63:20] <= {upper limit, limit[15:4]}. Register 3 holds the base in bits 15:0 and the limit in bits 31:16. The upper base is register 4 and the upper limit is register 5. The low nibble of each half of register 3 reads 1h. A 32-bit address hits this window when both upper words are 0 and it lies in range.
- R7: A window whose limit is below its base claims no address.
- R8: A configuration request hits when secondary <= bus <= subordinate. Register 0 holds the secondary bus in bits 7:0 and the subordinate bus in bits 15:8. A hit reports `rsp_type0` when the bus equals the secondary bus and `rsp_type1` otherwise. The two never assert together, and neither asserts without a hit.
- R9: While `mem_en` is 0, a memory request reports `rsp_unsup` and no hit.
- R10: While `io_en` is 0, an I/O request reports neither a hit nor an unsupported request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wsel | input | 3 | Write register index (0..5) |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 3 | Read register index (0..5) |
| cfg_rdata | output | 32 | Read data for `cfg_rsel` (combinational) |
| io_en | input | 1 | I/O space enable |
| mem_en | input | 1 | Memory space enable |
| io_1k | input | 1 | 1 KB I/O granularity mode |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | One-hot request kind: bit0 I/O, bit1 memory, bit2 configuration |
| req_addr | input | 64 | Request address |
| req_bus | input | 8 | Target bus number for configuration requests |
| rsp_valid | output | 1 | Response strobe, one cycle after `req_valid` |
| rsp_hit | output | 1 | Request falls inside a forwarding window |
| rsp_type0 | output | 1 | Configuration hit on the secondary bus |
| rsp_type1 | output | 1 | Configuration hit on a bus below the secondary bus |
| rsp_unsup | output | 1 | Memory request while memory space is disabled |

## Verification
A corrupted base, limit or bus register shows up at the ports as a wrong flag on the first request that lands on that boundary, one cycle after the strobe. A corrupted register also reads back wrong through the register port in the same cycle it is addressed. For this reason the stimulus probes each window at both of its edges and one step outside each edge. It also probes each window with an inverted range and with each enable off. A stuck 1K-mode mask shows up either as a window edge that moves by 1 KB or as nonzero read-back bits.

// File: rtl/bridge_window_decode.sv
module bridge_window_decode #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_wsel,
  input  logic [31:0]      cfg_wdata,
  input  logic [2:0]       cfg_rsel,
  output logic [31:0]      cfg_rdata,
  input  logic             io_en,
  input  logic             mem_en,
  input  logic             io_1k,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [63:0]      req_addr,
  input  logic [BUS_W-1:0] req_bus,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_type0,
  output logic             rsp_type1,
  output logic             rsp_unsup
);
  localparam int WIN_W = 12;
  localparam int PF_W  = 32 + WIN_W;

  logic [BUS_W-1:0] sec_bus, sub_bus;
  logic [3:0]       io_base_hi, io_lim_hi;
  logic [1:0]       io_base_lo, io_lim_lo;
  logic [WIN_W-1:0] mem_base, mem_lim, pf_base, pf_lim;
  logic [31:0]      pf_base_up, pf_lim_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_bus    <= '0;
      sub_bus    <= '0;
      io_base_hi <= 4'hF;
      io_lim_hi  <= 4'h0;
      io_base_lo <= 2'b00;
      io_lim_lo  <= 2'b00;
      mem_base   <= '1;
      mem_lim    <= '0;
      pf_base    <= '1;
      pf_lim     <= '0;
      pf_base_up <= '1;
      pf_lim_up  <= '0;
    end else if (cfg_wr) begin
      case (cfg_wsel)
        3'd0: begin
          sec_bus <= cfg_wdata[BUS_W-1:0];
          sub_bus <= cfg_wdata[8 +: BUS_W];
        end
        3'd1: begin
          io_base_hi <= cfg_wdata[7:4];
          io_lim_hi  <= cfg_wdata[15:12];
          if (io_1k) begin
            io_base_lo <= cfg_wdata[3:2];
            io_lim_lo  <= cfg_wdata[11:10];
          end
        end
        3'd2: begin
          mem_base <= cfg_wdata[15:4];
          mem_lim  <= cfg_wdata[31:20];
        end
        3'd3: begin
          pf_base <= cfg_wdata[15:4];
          pf_lim  <= cfg_wdata[31:20];
        end
        3'd4: pf_base_up <= cfg_wdata;
        3'd5: pf_lim_up  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  wire [1:0] io_base_fine = io_1k ? io_base_lo : 2'b00;
  wire [1:0] io_lim_fine  = io_1k ? io_lim_lo  : 2'b00;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_rsel)
      3'd0: begin
        cfg_rdata[BUS_W-1:0]  = sec_bus;
        cfg_rdata[8 +: BUS_W] = sub_bus;
      end
      3'd1: cfg_rdata = {16'h0, io_lim_hi, io_lim_fine, 2'b00,
                         io_base_hi, io_base_fine, 2'b00};
      3'd2: cfg_rdata = {mem_lim, 4'h0, mem_base, 4'h0};
      3'd3: cfg_rdata = {pf_lim, 4'h1, pf_base, 4'h1};
      3'd4: cfg_rdata = pf_base_up;
      3'd5: cfg_rdata = pf_lim_up;
      default: cfg_rdata = '0;
    endcase
  end

  wire kind_ok = $onehot(req_kind);
  wire is_io   = kind_ok && req_kind[0];
  wire is_mem  = kind_ok && req_kind[1];
  wire is_cfg  = kind_ok && req_kind[2];

  wire [5:0] io_lo_bound = {io_base_hi, io_base_fine};
  wire [5:0] io_hi_bound = {io_lim_hi, io_1k ? io_lim_lo : 2'b11};
  wire [5:0] io_a        = req_addr[15:10];
  wire io_in  = (req_addr[63:16] == '0) && (io_a >= io_lo_bound) && (io_a <= io_hi_bound);

  wire [WIN_W-1:0] mem_a = req_addr[31:20];
  wire mem_in = (req_addr[63:32] == '0) && (mem_a >= mem_base) && (mem_a <= mem_lim);

  wire [PF_W-1:0] pf_a = req_addr[63:20];
  wire pf_in  = (pf_a >= {pf_base_up, pf_base}) && (pf_a <= {pf_lim_up, pf_lim});

  wire cfg_in = (req_bus >= sec_bus) && (req_bus <= sub_bus);

  wire hit_d   = (is_io && io_en && io_in) || (is_mem && mem_en && (mem_in || pf_in)) ||
                 (is_cfg && cfg_in);
  wire unsup_d = is_mem && !mem_en;
  wire t0_d    = is_cfg && cfg_in && (req_bus == sec_bus);
  wire t1_d    = is_cfg && cfg_in && (req_bus != sec_bus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_type0 <= 1'b0;
      rsp_type1 <= 1'b0;
      rsp_unsup <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit_d;
      rsp_type0 <= req_valid && t0_d;
      rsp_type1 <= req_valid && t1_d;
      rsp_unsup <= req_valid && unsup_d;
    end
  end
endmodule

module bridge_window_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       io_en,
  input logic       mem_en,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_type0,
  input logic       rsp_type1,
  input logic       rsp_unsup
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_type0 || rsp_type1 || rsp_unsup));
  a_r8_type_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_type0, rsp_type1}));
  a_r8_type_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_type0 || rsp_type1) |-> rsp_hit);
  a_r9_mem_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'b010 && !mem_en) |=> (rsp_unsup && !rsp_hit));
  a_r10_io_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'b001 && !io_en) |=> (!rsp_hit && !rsp_unsup));
endmodule

bind bridge_window_decode bridge_window_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .io_en(io_en), .mem_en(mem_en), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_type0(rsp_type0), .rsp_type1(rsp_type1), .rsp_unsup(rsp_unsup)
);

// File: tb/bridge_window_decode_test.sv
module bridge_window_decode_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_wsel = '0, cfg_rsel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic io_en = 1'b1, mem_en = 1'b1, io_1k = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [63:0] req_addr = '0;
  logic [7:0] req_bus = '0;
  logic rsp_valid, rsp_hit, rsp_type0, rsp_type1, rsp_unsup;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];

  localparam logic [2:0] K_IO = 3'b001, K_MEM = 3'b010, K_CFG = 3'b100;

  always #2 clk = ~clk;

  bridge_window_decode uut (.*);

  // monitor: compares {hit,type0,type1,unsup} against the queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response act=%b exp=none", {rsp_hit, rsp_type0, rsp_type1, rsp_unsup});
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_hit, rsp_type0, rsp_type1, rsp_unsup} !== e) begin
          errors++;
          $display("FAIL %s act=%b exp=%b", t, {rsp_hit, rsp_type0, rsp_type1, rsp_unsup}, e);
        end
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [63:0] a, input logic [7:0] b,
                      input logic [3:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_bus = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_wsel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] e, input string t);
    cfg_rsel = s;
    #1;
    checks++;
    if (cfg_rdata !== e) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, cfg_rdata, e);
    end
  endtask

  task automatic drain;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
          errors++; $display("FAIL R2 idle act=%b exp=0", rsp_valid);
        end
        rd(3'd1, 32'h0000_00F0, "R1 io reset");
        rd(3'd2, 32'h0000_FFF0, "R1 mem reset");
        rd(3'd3, 32'h0001_FFF1, "R1 pf reset");
        rd(3'd4, 32'hFFFF_FFFF, "R1 pf base up reset");
        rd(3'd5, 32'h0000_0000, "R1 pf lim up reset");
        rd(3'd0, 32'h0000_0000, "R1 bus reset");
        @(negedge clk);
        send(K_IO,  64'hF000, 0, 4'b0000, "R1 io empty");
        send(K_MEM, 64'h0, 0, 4'b0000, "R1 mem empty low");
        send(K_MEM, 64'hFFF0_0000, 0, 4'b0000, "R1 mem empty high");
        send(K_MEM, 64'hFFFF_FFFF_FFF0_0000, 0, 4'b0000, "R1 pf empty");
        send(K_CFG, 0, 8'd0, 4'b1100, "R8 reset bus0 type0");
        drain();

        wr(3'd0, 32'h0000_0804);
        send(K_CFG, 0, 8'd3, 4'b0000, "R8 below secondary");
        send(K_CFG, 0, 8'd4, 4'b1100, "R8 secondary type0");
        send(K_CFG, 0, 8'd6, 4'b1010, "R8 middle type1");
        send(K_CFG, 0, 8'd8, 4'b1010, "R8 subordinate type1");
        send(K_CFG, 0, 8'd9, 4'b0000, "R8 above subordinate");
        drain();

        wr(3'd1, 32'h0000_4F2C);
        rd(3'd1, 32'h0000_4020, "R4 low bits read 0 without 1k");
        send(K_IO, 64'h2000, 0, 4'b1000, "R3 io base edge");
        send(K_IO, 64'h1FFF, 0, 4'b0000, "R3 io below base");
        send(K_IO, 64'h4FFF, 0, 4'b1000, "R3 io limit top");
        send(K_IO, 64'h5000, 0, 4'b0000, "R3 io above limit");
        send(K_IO, 64'h1_0000_2000, 0, 4'b0000, "R3 io upper bits");
        drain();

        io_1k = 1'b1;
        wr(3'd1, 32'h0000_4824);
        rd(3'd1, 32'h0000_4824, "R4 1k bits readable");
        send(K_IO, 64'h2400, 0, 4'b1000, "R4 1k base edge");
        send(K_IO, 64'h23FF, 0, 4'b0000, "R4 1k below base");
        send(K_IO, 64'h4BFF, 0, 4'b1000, "R4 1k limit top");
        send(K_IO, 64'h4C00, 0, 4'b0000, "R4 1k above limit");
        drain();
        io_1k = 1'b0;
        rd(3'd1, 32'h0000_4020, "R4 masked after 1k off");
        send(K_IO, 64'h2000, 0, 4'b1000, "R4 4k base after 1k off");
        send(K_IO, 64'h4FFF, 0, 4'b1000, "R4 4k top after 1k off");
        drain();

        io_en = 1'b0;
        send(K_IO, 64'h3000, 0, 4'b0000, "R10 io disabled");
        drain();
        io_en = 1'b1;

        wr(3'd2, 32'h2FF5_100F);
        rd(3'd2, 32'h2FF0_1000, "R5 mem readback");
        send(K_MEM, 64'h1000_0000, 0, 4'b1000, "R5 mem base edge");
        send(K_MEM, 64'h0FFF_FFFF, 0, 4'b0000, "R5 mem below base");
        send(K_MEM, 64'h2FFF_FFFF, 0, 4'b1000, "R5 mem limit top");
        send(K_MEM, 64'h3000_0000, 0, 4'b0000, "R5 mem above limit");
        send(K_MEM, 64'h1_1000_0000, 0, 4'b0000, "R5 mem upper bits");
        drain();

        mem_en = 1'b0;
        send(K_MEM, 64'h1000_0000, 0, 4'b0001, "R9 mem disabled");
        drain();
        mem_en = 1'b1;

        wr(3'd4, 32'h1);
        wr(3'd5, 32'h2);
        wr(3'd3, 32'h0000_8000);
        rd(3'd3, 32'h0001_8001, "R6 pf low nibble 1h");
        send(K_MEM, 64'h1_8000_0000, 0, 4'b1000, "R6 pf base edge");
        send(K_MEM, 64'h1_7FFF_FFFF, 0, 4'b0000, "R6 pf below base");
        send(K_MEM, 64'h2_000F_FFFF, 0, 4'b1000, "R6 pf limit top");
        send(K_MEM, 64'h2_0010_0000, 0, 4'b0000, "R6 pf above limit");
        drain();

        wr(3'd2, 32'h0FF0_1000);
        send(K_MEM, 64'h1000_0000, 0, 4'b0000, "R7 mem inverted at base");
        send(K_MEM, 64'h0FF0_0000, 0, 4'b0000, "R7 mem inverted at limit");
        wr(3'd5, 32'h0);
        send(K_MEM, 64'h1_8000_0000, 0, 4'b0000, "R7 pf inverted");
        wr(3'd1, 32'h0000_1030);
        send(K_IO, 64'h3000, 0, 4'b0000, "R7 io inverted");
        drain();

        wr(3'd4, 32'h0);
        wr(3'd3, 32'h4FF0_4000);
        send(K_MEM, 64'h4000_0000, 0, 4'b1000, "R6 pf 32-bit base");
        send(K_MEM, 64'h4FFF_FFFF, 0, 4'b1000, "R6 pf 32-bit top");
        send(K_MEM, 64'h5000_0000, 0, 4'b0000, "R6 pf 32-bit above");
        drain();

        checks++;
        if (exp_q.size() != 0) begin
          errors++;
          $display("FAIL R2 missing responses act=%0d exp=0", exp_q.size());
        end
      end
      begin
        repeat (20000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule